// File: doc/BRIEF.md
# Serial RGB LED Waveform Encoder

This block drives the single data wire of a chain of addressable RGB LEDs. A frame starts with a request that carries the number of LEDs. The block then pulls one 24-bit colour word per LED from a valid/ready stream and sends every bit as a fixed-length pulse. The length of the high part of the pulse gives the bit value. The pulse is made the way a PWM compare channel makes it. A bit-period counter runs from zero to the end of the period and is compared with a per-bit high-time value. That value changes only when a period starts.

After the last data bit the block sends one more period that stays low, so the wire rests low. It then stops the counter, drops busy and gives a one-cycle done pulse. A request that arrives during a frame does not interrupt it. A request that is still held when the frame ends is taken in the next cycle. Two error pulses report an LED count outside the allowed range and a colour stream that had no word ready when one was needed.

The controller has four states. IDLE holds the counter at zero and the output low. LOAD requests the first colour word. SEND shifts out the data bits. TAIL sends the closing low period. The transitions are:

- IDLE to LOAD: a request arrives with a count from 1 to MAX_LEDS.
- LOAD to SEND: the first word is present.
- LOAD to IDLE: the first word is missing (underrun).
- SEND to SEND: the next bit starts, or the next word is taken after the last bit of a word.
- SEND to IDLE: the next word is missing (underrun).
- SEND to TAIL: the last bit of the last word has been sent.
- TAIL to IDLE: the closing period is over.

Top module: `rgbled_encoder`

## Requirements
- R1: Out of reset and whenever the block is idle, `dout_o`, `busy_o` and `pix_ready_o` are low.
- R2: A bit period lasts PER = PERIOD_NS·CLK_HZ/10^9 clock cycles, with integer division. The output is high for the first HI1 = ONE_NS·CLK_HZ/10^9 cycles of a period for a 1 bit, and for the first HI0 = ZERO_NS·CLK_HZ/10^9 cycles for a 0 bit. It is low for the rest of the period.
- R3: Each LED word is 24 bits. Bit 23 is sent first and bit 0 last, and the words go out in stream order with no gap between consecutive bits.
- R4: `pix_ready_o` is high in the cycle after a request is accepted, so the first word is taken then, and its bit 23 starts in the following cycle. Each later word is taken in the last cycle of bit 0 of the word before it.
- R5: After the last data bit there is one more period of PER cycles with the output low. Then `done_o` is high for exactly one cycle.
- R6: `busy_o` is high from the cycle after a request is accepted until the closing period ends. It is low in the cycle where `done_o` is high.
- R7: A request raised during a frame does not change that frame's waveform. If the request is still held when the frame ends, it is accepted right after the done cycle.
- R8: A request whose count is 0 or greater than MAX_LEDS is refused. `err_count_o` pulses for one cycle in the next cycle and the block stays idle.
- R9: If `pix_valid_i` is low while `pix_ready_o` is high, the frame is dropped. In the next cycle `err_underrun_o` pulses, the output is low and busy is low, and no done pulse follows.
- R10: The compare value stays constant within a period. The output can rise only in the first cycle of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Frame request; accepted only when idle |
| led_count_i | input | CNT_W | Number of LEDs in the requested frame |
| pix_valid_i | input | 1 | Colour word present |
| pix_data_i | input | 24 | Colour word; bit 23 is sent first |
| pix_ready_o | output | 1 | Colour word taken on this edge if valid |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at the end of a frame |
| err_count_o | output | 1 | One-cycle pulse: request refused for a bad count |
| err_underrun_o | output | 1 | One-cycle pulse: frame dropped because no word was present |
| dout_o | output | 1 | Serial LED data line |

## Verification
The properties assume that the clock parameter gives 0 < HI0 < HI1 < PER. This keeps the line low in the last cycle of every period, so a rising edge is only possible at a period boundary. The properties also assume that an underrun can come only from a missing word while ready is high, so `pix_valid_i` is treated as a free input. The bench runs with a 10 MHz clock parameter, which gives PER = 12, HI1 = 6 and HI0 = 3, and MAX_LEDS = 4. It keeps the stream valid for the whole of every normal frame. It starves the stream only on purpose, at the first word or at the second word. It changes inputs only at falling clock edges.

// File: rtl/rgbled_enc_pkg.sv
package rgbled_enc_pkg;

    localparam int unsigned CH_BITS   = 8;
    localparam int unsigned CH_NUM    = 3;
    localparam int unsigned WORD_BITS = CH_BITS * CH_NUM;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOAD = 2'd1,
        S_SEND = 2'd2,
        S_TAIL = 2'd3
    } enc_state_e;

    // nanoseconds to whole clock cycles, truncating
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned hz);
        longint unsigned prod;
        prod = longint'(ns) * longint'(hz);
        return 32'(prod / 64'd1000000000);
    endfunction

endpackage

// File: rtl/rgbled_period_ctr.sv
module rgbled_period_ctr #(
    parameter int unsigned PER_CYC = 150,
    parameter int unsigned PER_W   = $clog2(PER_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             cmp_wr_i,
    input  logic [PER_W-1:0] cmp_nxt_i,
    output logic             wrap_o,
    output logic             pwm_o
);
    localparam logic [PER_W-1:0] LAST_CNT = PER_W'(PER_CYC - 1);

    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] cmp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || cnt_q == LAST_CNT) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PER_W'(1);
        end
    end

    // compare value is written only at a period boundary (or before the first one)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (cmp_wr_i) begin
            cmp_q <= cmp_nxt_i;
        end
    end

    assign wrap_o = run_i && (cnt_q == LAST_CNT);
    assign pwm_o  = run_i && (cnt_q < cmp_q);

endmodule

// File: rtl/rgbled_word_shift.sv
module rgbled_word_shift #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_i,
    input  logic         sh_i,
    input  logic [W-1:0] din_i,
    output logic         nxt_bit_o,
    output logic         last_o
);
    localparam int unsigned IDX_W = $clog2(W);

    logic [W-1:0]     sh_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (ld_i) begin
            sh_q  <= din_i;
            idx_q <= IDX_W'(W - 1);
        end else if (sh_i) begin
            sh_q  <= {sh_q[W-2:0], 1'b0};
            idx_q <= idx_q - IDX_W'(1);
        end
    end

    assign nxt_bit_o = sh_q[W-2];
    assign last_o    = (idx_q == '0);

endmodule

// File: rtl/rgbled_encoder.sv
module rgbled_encoder
    import rgbled_enc_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 125000000,
    parameter int unsigned MAX_LEDS  = 8,
    parameter int unsigned PERIOD_NS = 1200,
    parameter int unsigned ONE_NS    = 600,
    parameter int unsigned ZERO_NS   = 300,
    parameter int unsigned CNT_W     = $clog2(MAX_LEDS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [CNT_W-1:0]     led_count_i,
    input  logic                 pix_valid_i,
    input  logic [WORD_BITS-1:0] pix_data_i,
    output logic                 pix_ready_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 err_count_o,
    output logic                 err_underrun_o,
    output logic                 dout_o
);
    localparam int unsigned PER_CYC = ns_to_cyc(PERIOD_NS, CLK_HZ);
    localparam int unsigned HI1_CYC = ns_to_cyc(ONE_NS, CLK_HZ);
    localparam int unsigned HI0_CYC = ns_to_cyc(ZERO_NS, CLK_HZ);
    localparam int unsigned PER_W   = $clog2(PER_CYC + 1);

    localparam logic [PER_W-1:0] CMP_ONE  = PER_W'(HI1_CYC);
    localparam logic [PER_W-1:0] CMP_ZERO = PER_W'(HI0_CYC);
    localparam logic [PER_W-1:0] CMP_OFF  = '0;
    localparam logic [CNT_W-1:0] MAX_C    = CNT_W'(MAX_LEDS);
    localparam logic [CNT_W-1:0] ONE_C    = CNT_W'(1);

    enc_state_e       state_q, state_d;
    logic [CNT_W-1:0] left_q;

    logic             wrap, last_bit, nxt_bit, run;
    logic             req_ok, need_word, take, starve, shift_bit, go_tail;
    logic             cmp_wr;
    logic [PER_W-1:0] cmp_nxt;

    rgbled_period_ctr #(.PER_CYC(PER_CYC), .PER_W(PER_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .cmp_wr_i  (cmp_wr),
        .cmp_nxt_i (cmp_nxt),
        .wrap_o    (wrap),
        .pwm_o     (dout_o)
    );

    rgbled_word_shift #(.W(WORD_BITS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_i      (take),
        .sh_i      (shift_bit),
        .din_i     (pix_data_i),
        .nxt_bit_o (nxt_bit),
        .last_o    (last_bit)
    );

    assign req_ok    = (led_count_i != '0) && (led_count_i <= MAX_C);
    assign run       = (state_q == S_SEND) || (state_q == S_TAIL);
    assign need_word = (state_q == S_LOAD) ||
                       ((state_q == S_SEND) && wrap && last_bit && (left_q > ONE_C));
    assign take      = need_word && pix_valid_i;
    assign starve    = need_word && !pix_valid_i;
    assign shift_bit = (state_q == S_SEND) && wrap && !last_bit;
    assign go_tail   = (state_q == S_SEND) && wrap && last_bit && (left_q <= ONE_C);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start_i && req_ok) state_d = S_LOAD;
            S_LOAD: state_d = pix_valid_i ? S_SEND : S_IDLE;
            S_SEND: begin
                if (go_tail)     state_d = S_TAIL;
                else if (starve) state_d = S_IDLE;
            end
            S_TAIL: if (wrap) state_d = S_IDLE;
        endcase
    end

    // compare preload selection
    always_comb begin
        cmp_wr  = take || shift_bit || go_tail;
        cmp_nxt = CMP_OFF;
        if (take)           cmp_nxt = pix_data_i[WORD_BITS-1] ? CMP_ONE : CMP_ZERO;
        else if (shift_bit) cmp_nxt = nxt_bit ? CMP_ONE : CMP_ZERO;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start_i && req_ok) left_q <= led_count_i;
            else if (take && state_q == S_SEND)         left_q <= left_q - ONE_C;
        end
    end

    // registered status pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o         <= 1'b0;
            err_count_o    <= 1'b0;
            err_underrun_o <= 1'b0;
        end else begin
            done_o         <= (state_q == S_TAIL) && wrap;
            err_count_o    <= (state_q == S_IDLE) && start_i && !req_ok;
            err_underrun_o <= starve;
        end
    end

    assign pix_ready_o = need_word;
    assign busy_o      = (state_q != S_IDLE);

endmodule

// File: rtl/rgbled_encoder_chk.sv
module rgbled_encoder_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic dout,
    input logic done,
    input logic err_cnt,
    input logic err_ur,
    input logic ready,
    input logic valid
);
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dout); // R1
    AST_READY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> busy); // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_DONE_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R6
    AST_COUNT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt |-> (!busy && !$past(busy))); // R8
    AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_ur |-> (!busy && !dout && $past(ready && !valid))); // R9
endmodule

module rgbled_period_chk #(
    parameter int unsigned PER_CYC = 150,
    parameter int unsigned PER_W   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [PER_W-1:0] cnt,
    input logic [PER_W-1:0] cmp,
    input logic             pwm
);
    AST_RISE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm) |-> (cnt == '0)); // R10
    AST_CMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt != '0) |-> $stable(cmp)); // R10
    AST_CMP_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cmp < PER_W'(PER_CYC))); // R2
endmodule

bind rgbled_encoder rgbled_encoder_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy_o),
    .dout    (dout_o),
    .done    (done_o),
    .err_cnt (err_count_o),
    .err_ur  (err_underrun_o),
    .ready   (pix_ready_o),
    .valid   (pix_valid_i)
);

bind rgbled_period_ctr rgbled_period_chk #(.PER_CYC(PER_CYC), .PER_W(PER_W)) u_pchk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_i),
    .cnt   (cnt_q),
    .cmp   (cmp_q),
    .pwm   (pwm_o)
);

// File: tb/rgbled_encoder_bench.sv
module rgbled_encoder_bench;
    localparam int unsigned CLK_HZ   = 10000000;
    localparam int unsigned MAX_LEDS = 4;
    localparam int unsigned CNT_W    = $clog2(MAX_LEDS + 1);
    localparam int PER = int'((64'd1200 * 64'(CLK_HZ)) / 64'd1000000000);
    localparam int HI1 = int'((64'd600  * 64'(CLK_HZ)) / 64'd1000000000);
    localparam int HI0 = int'((64'd300  * 64'(CLK_HZ)) / 64'd1000000000);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] led_count = '0;
    logic             pix_valid = 1'b0;
    logic [23:0]      pix_data = '0;
    logic             pix_ready, busy, done, err_count, err_underrun, dout;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [23:0] words [0:3];
    int feed_idx = 0;
    int feed_lim = 0;
    bit pend = 1'b0;

    always #4 clk = ~clk;

    rgbled_encoder #(.CLK_HZ(CLK_HZ), .MAX_LEDS(MAX_LEDS)) u_rgbled_encoder (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start),
        .led_count_i    (led_count),
        .pix_valid_i    (pix_valid),
        .pix_data_i     (pix_data),
        .pix_ready_o    (pix_ready),
        .busy_o         (busy),
        .done_o         (done),
        .err_count_o    (err_count),
        .err_underrun_o (err_underrun),
        .dout_o         (dout)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    // colour stream model: a word is consumed at the edge after ready&&valid is seen
    initial begin
        forever begin
            @(negedge clk);
            if (pend) feed_idx++;
            pix_valid = (feed_idx < feed_lim);
            pix_data  = (feed_idx < 4) ? words[feed_idx] : 24'h0;
            pend      = pix_ready && pix_valid;
        end
    end

    task automatic feed_setup(input int lim);
        feed_idx  = 0;
        feed_lim  = lim;
        pix_valid = (lim > 0);
        pix_data  = words[0];
    endtask

    // checks one data bit, PER falling edges
    task automatic check_bit(input int g, input bit mid_req);
        logic [23:0] w;
        int hi;
        int bad;
        int ones;
        w = words[g / 24];
        hi = w[23 - (g % 24)] ? HI1 : HI0;
        bad = 0;
        ones = 0;
        for (int c = 0; c < PER; c++) begin
            @(negedge clk);
            if (mid_req && g == 30 && c == 0) begin
                start = 1'b1;
                led_count = CNT_W'(2);
            end
            if (dout !== (c < hi)) bad++;
            if (dout === 1'b1) ones++;
            if (busy !== 1'b1) bad++;
        end
        chk(bad == 0, "R2 R3", $sformatf("bit %0d high-time", g), ones, hi);
    endtask

    task automatic frame_body(input int n, input bit mid_req);
        int bad;
        for (int g = 0; g < 24 * n; g++) check_bit(g, mid_req);
        bad = 0;
        for (int c = 0; c < PER; c++) begin
            @(negedge clk);
            if (dout !== 1'b0 || done !== 1'b0 || busy !== 1'b1) bad++;
        end
        chk(bad == 0, "R5", "closing period low", bad, 0);
        @(negedge clk);
        chk(done === 1'b1 && dout === 1'b0, "R5", "done after closing period", done, 1);
        chk(busy === 1'b0, "R6", "busy low at done", busy, 0);
        if (!mid_req) begin
            @(negedge clk);
            chk(done === 1'b0 && busy === 1'b0 && dout === 1'b0, "R5", "done one cycle", done, 0);
        end
    endtask

    task automatic frame(input int n);
        feed_setup(n);
        start = 1'b1;
        led_count = CNT_W'(n);
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1 && pix_ready === 1'b1 && dout === 1'b0, "R4 R6",
            "first word requested", {busy, pix_ready, dout}, 3'b110);
        frame_body(n, 1'b0);
    endtask

    task automatic fill(input int p);
        for (int k = 0; k < 4; k++) begin
            case (p)
                0: words[k] = 24'h000000;
                1: words[k] = 24'hFFFFFF;
                2: words[k] = 24'h800001 >> k;
                default: words[k] = 24'(((k + 1) * 32'h003AC517) ^ 32'h5A5A5A);
            endcase
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
    end

    initial begin
        fill(0);
        repeat (3) @(negedge clk);
        chk(dout === 1'b0 && busy === 1'b0 && pix_ready === 1'b0, "R1", "in reset",
            {dout, busy, pix_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dout === 1'b0 && busy === 1'b0 && pix_ready === 1'b0 && done === 1'b0, "R1",
            "idle after reset", {dout, busy, pix_ready, done}, 0);

        // sweep of LED counts and colour patterns
        for (int n = 1; n <= 4; n++) begin
            for (int p = 0; p < 4; p++) begin
                fill(p);
                frame(n);
            end
        end

        // refused counts
        for (int v = 0; v < 3; v++) begin
            start = 1'b1;
            led_count = (v == 0) ? CNT_W'(0) : (v == 1) ? CNT_W'(MAX_LEDS + 1) : CNT_W'(7);
            @(negedge clk);
            start = 1'b0;
            chk(err_count === 1'b1 && busy === 1'b0 && pix_ready === 1'b0, "R8",
                "bad count refused", {err_count, busy}, 2'b10);
            @(negedge clk);
            chk(err_count === 1'b0 && busy === 1'b0 && dout === 1'b0, "R8",
                "stays idle", {err_count, busy, dout}, 0);
        end

        // request raised during a frame and held
        fill(3);
        feed_setup(3);
        start = 1'b1;
        led_count = CNT_W'(3);
        @(negedge clk);
        start = 1'b0;
        frame_body(3, 1'b1);
        fill(2);
        feed_setup(2);
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1 && pix_ready === 1'b1, "R7", "held request taken after done",
            {busy, pix_ready}, 2'b11);
        frame_body(2, 1'b0);

        // underrun on the first word
        fill(1);
        feed_setup(0);
        start = 1'b1;
        led_count = CNT_W'(2);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(err_underrun === 1'b1 && busy === 1'b0 && dout === 1'b0, "R9",
            "first-word underrun", {err_underrun, busy, dout}, 3'b100);
        @(negedge clk);
        chk(err_underrun === 1'b0 && done === 1'b0, "R9", "underrun pulse one cycle",
            err_underrun, 0);

        // underrun on the second word
        fill(3);
        feed_setup(1);
        start = 1'b1;
        led_count = CNT_W'(3);
        @(negedge clk);
        start = 1'b0;
        for (int g = 0; g < 24; g++) check_bit(g, 1'b0);
        @(negedge clk);
        chk(err_underrun === 1'b1 && busy === 1'b0 && dout === 1'b0, "R9",
            "mid-frame underrun", {err_underrun, busy, dout}, 3'b100);
        begin
            int bad;
            bad = 0;
            repeat (2 * PER) begin
                @(negedge clk);
                if (dout !== 1'b0 || done !== 1'b0 || busy !== 1'b0 || err_underrun !== 1'b0) bad++;
            end
            chk(bad == 0, "R9", "line low and no done after underrun", bad, 0);
        end

        // recovery after underrun
        fill(2);
        frame(1);

        summary();
    end
endmodule